// File: doc/BRIEF.md
# Byte-Sequencing Flash Bus Bridge

This block links a 16-bit host register bus to a raw 8-bit NAND flash bus. The host sees three byte-addressable locations: a data port, a control byte whose bits drive the flash chip-enable, command-latch, address-latch and write-protect lines, and a read-only status byte. The status byte reports the flash ready/busy line after a synchronizer.

Any access to the data port while the chip is selected becomes a train of flash bus cycles. A 16-bit access runs two byte cycles, and the low half of the host word always goes first on the flash bus. A byte-wide write runs exactly one cycle, which is how software issues command and address bytes. Each byte cycle has a parameterised number of setup, strobe-low and hold clocks. The host request is stretched until the last cycle finishes, and `host_ready` pulses for one clock on completion. When the chip is deselected (standby), data-port accesses finish at once, the flash lines stay quiet and reads return all ones.

Top module: `nand_byte_bridge`

## Requirements
- R1: While reset is held and just after it, the control byte is 0x00, `nand_ce_n`, `nand_we_n` and `nand_re_n` are 1, `nand_cle`, `nand_ale`, `nand_wp_n`, `nand_dq_oe` and `host_ready` are 0.
- R2: The control byte sits at offset 4. A write stores `host_wdata[7:0]`, and a read returns it in `host_rdata[7:0]` with the upper byte zero. Bit 0 drives `nand_cle`, bit 1 drives `nand_ale`, bit 4 selects the chip (`nand_ce_n` = not bit 4) and bit 7 drives `nand_wp_n`. The remaining bits are stored and read back only. Typical values are 0x94 for data, 0x95 for command, 0x96 for address and 0x00 for standby.
- R3: The status byte at offset 5 reads bit 7 = 1 while `nand_rb_n` is low (after the synchronizer), and all other bits read 0. Writes to it have no effect.
- R4: A 16-bit write to the data port (offset 0) runs two flash write cycles: `host_wdata[7:0]` first, then `host_wdata[15:8]`. The output data is stable while `nand_we_n` is low.
- R5: A 16-bit read of the data port runs two flash read cycles. The first byte received lands in `host_rdata[7:0]` and the second in `host_rdata[15:8]`.
- R6: A byte-wide write to the data port runs exactly one flash write cycle carrying `host_wdata[7:0]`.
- R7: A byte-wide read of the data port runs exactly one flash read cycle. The byte is returned in `host_rdata[7:0]`, with the upper byte 0.
- R8: Each flash byte cycle holds its strobe low for STROBE_CYC clocks after SETUP_CYC setup clocks and before HOLD_CYC hold clocks. Counted in clocks from the accepting edge up to the one where `host_ready` is seen, completion takes 2·(S+P+H)+1 for a 16-bit data access, S+P+H+1 for a byte data access and 1 for a register access.
- R9: `host_ready` is high for exactly one clock per access. `nand_we_n` and `nand_re_n` are never low together. `nand_dq_oe` is never high during a read strobe.
- R10: With control bit 4 clear, a data-port access completes in one clock with no strobe activity. A 16-bit read returns 0xFFFF and a byte read returns 0x00FF.
- R11: Offsets other than 0, 4 and 5 read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Access request, held until `host_ready` |
| host_we | input | 1 | 1 = write, 0 = read |
| host_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| host_addr | input | ADDR_W | Byte offset |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid with `host_ready` |
| host_ready | output | 1 | One-clock completion pulse |
| nand_ce_n | output | 1 | Flash chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_wp_n | output | 1 | Write-protect release |
| nand_dq_o | output | 8 | Flash data out |
| nand_dq_oe | output | 1 | Flash data output enable |
| nand_dq_i | input | 8 | Flash data in |
| nand_rb_n | input | 1 | Flash ready/busy, low = busy |

## Verification
The data port is driven with 16-bit writes and reads, byte-wide writes and reads, and the same accesses in standby. This separates the two-cycle, one-cycle and zero-cycle paths. It also shows byte order through unequal halves such as 0xBEEF, whose swap would be visible. Register traffic to the control, status and unmapped offsets is interleaved with the data traffic, so that completion latency, read-back and ignored writes can be told apart. The strobe-low clocks are counted for every access to pin the timing parameters to the flash bus.

// File: rtl/nbb_pkg.sv
package nbb_pkg;
    localparam int BYTE_W   = 8;
    localparam int HOST_W   = 2 * BYTE_W;
    localparam int CTL_CLE  = 0;
    localparam int CTL_ALE  = 1;
    localparam int CTL_SEL  = 4;
    localparam int CTL_WPR  = 7;
    localparam int STAT_BSY = 7;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_DONE
    } phase_e;
endpackage

// File: rtl/nbb_decode.sv
module nbb_decode #(
    parameter int ADDR_W   = 3,
    parameter int OFF_DATA = 0,
    parameter int OFF_CTL  = 4,
    parameter int OFF_STAT = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_data,
    output logic              hit_ctl,
    output logic              hit_stat
);
    localparam logic [ADDR_W-1:0] A_DATA = OFF_DATA[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_CTL  = OFF_CTL[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_STAT = OFF_STAT[ADDR_W-1:0];

    always_comb begin
        hit_data = (addr == A_DATA);
        hit_ctl  = (addr == A_CTL);
        hit_stat = (addr == A_STAT);
    end
endmodule

// File: rtl/nbb_regs.sv
module nbb_regs
    import nbb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [BYTE_W-1:0] ctl_wdata,
    input  logic              rb_n,
    output logic [BYTE_W-1:0] ctl,
    output logic              flash_busy
);
    typedef struct packed {
        logic [BYTE_W-1:0]      ctl;
        logic [SYNC_STAGES-1:0] sync;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], rb_n};
        if (ctl_wr) begin
            st_d.ctl = ctl_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctl  <= '0;
            st_q.sync <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl        = st_q.ctl;
    assign flash_busy = ~st_q.sync[SYNC_STAGES-1];

    // R2
    ctl_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.ctl) |-> $past(ctl_wr));
endmodule

// File: rtl/nbb_seq.sv
module nbb_seq
    import nbb_pkg::*;
#(
    parameter int SETUP_CYC  = 2,
    parameter int STROBE_CYC = 3,
    parameter int HOLD_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_wr,
    input  logic              start_wide,
    input  logic              start_skip,
    input  logic [HOST_W-1:0] skip_rdata,
    input  logic [HOST_W-1:0] wdata,
    input  logic [BYTE_W-1:0] dq_i,
    output logic              idle,
    output logic              done,
    output logic [HOST_W-1:0] rdata,
    output logic              we_n,
    output logic              re_n,
    output logic [BYTE_W-1:0] dq_o,
    output logic              dq_oe
);
    localparam int MAX_A = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
    localparam int MAX_C = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
    localparam int CW    = $clog2(MAX_C + 1);
    localparam logic [CW-1:0] LAST_SU = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] LAST_ST = CW'(STROBE_CYC - 1);
    localparam logic [CW-1:0] LAST_HO = CW'(HOLD_CYC - 1);

    typedef struct packed {
        phase_e            ph;
        logic [CW-1:0]     cnt;
        logic              second;
        logic              wide;
        logic              wr;
        logic [HOST_W-1:0] wd;
        logic [HOST_W-1:0] rd;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (start) begin
                    s_d.wide   = start_wide;
                    s_d.wr     = start_wr;
                    s_d.wd     = wdata;
                    s_d.second = 1'b0;
                    s_d.cnt    = '0;
                    s_d.rd     = '0;
                    if (start_skip) begin
                        s_d.ph = PH_DONE;
                        s_d.rd = skip_rdata;
                    end else begin
                        s_d.ph = PH_SETUP;
                    end
                end
            end
            PH_SETUP: begin
                if (s_q.cnt == LAST_SU) begin
                    s_d.ph  = PH_STROBE;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            PH_STROBE: begin
                if (s_q.cnt == LAST_ST) begin
                    s_d.ph  = PH_HOLD;
                    s_d.cnt = '0;
                    if (!s_q.wr) begin
                        if (s_q.second) s_d.rd[HOST_W-1:BYTE_W] = dq_i;
                        else            s_d.rd[BYTE_W-1:0]      = dq_i;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            PH_HOLD: begin
                if (s_q.cnt == LAST_HO) begin
                    s_d.cnt = '0;
                    if (s_q.wide && !s_q.second) begin
                        s_d.second = 1'b1;
                        s_d.ph     = PH_SETUP;
                    end else begin
                        s_d.ph = PH_DONE;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            PH_DONE: s_d.ph = PH_IDLE;
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    logic in_cycle;
    always_comb begin
        in_cycle = (s_q.ph == PH_SETUP) || (s_q.ph == PH_STROBE) || (s_q.ph == PH_HOLD);
        idle     = (s_q.ph == PH_IDLE);
        done     = (s_q.ph == PH_DONE);
        rdata    = s_q.rd;
        dq_o     = s_q.second ? s_q.wd[HOST_W-1:BYTE_W] : s_q.wd[BYTE_W-1:0];
        dq_oe    = s_q.wr && in_cycle;
        we_n     = !(s_q.wr && (s_q.ph == PH_STROBE));
        re_n     = !(!s_q.wr && (s_q.ph == PH_STROBE));
    end

    // R4
    wr_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n)) |-> $stable(dq_o));

    // R9
    oe_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> re_n);

    // R8
    strobe_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_STROBE) |-> (s_q.cnt <= LAST_ST));
endmodule

// File: rtl/nand_byte_bridge.sv
module nand_byte_bridge
    import nbb_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int OFF_DATA    = 0,
    parameter int OFF_CTL     = 4,
    parameter int OFF_STAT    = 5,
    parameter int SETUP_CYC   = 2,
    parameter int STROBE_CYC  = 3,
    parameter int HOLD_CYC    = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic              host_wide,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata,
    output logic              host_ready,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic              nand_wp_n,
    output logic [7:0]        nand_dq_o,
    output logic              nand_dq_oe,
    input  logic [7:0]        nand_dq_i,
    input  logic              nand_rb_n
);
    logic              hit_data, hit_ctl, hit_stat;
    logic [BYTE_W-1:0] ctl;
    logic              flash_busy;
    logic              seq_idle;
    logic              start, skip, ctl_wr;
    logic [HOST_W-1:0] skip_rdata;

    nbb_decode #(
        .ADDR_W(ADDR_W), .OFF_DATA(OFF_DATA), .OFF_CTL(OFF_CTL), .OFF_STAT(OFF_STAT)
    ) u_dec (
        .addr(host_addr), .hit_data(hit_data), .hit_ctl(hit_ctl), .hit_stat(hit_stat)
    );

    always_comb begin
        start  = host_req && seq_idle;
        skip   = !hit_data || !ctl[CTL_SEL];
        ctl_wr = start && host_we && hit_ctl;
        skip_rdata = '0;
        if (hit_ctl) begin
            skip_rdata[BYTE_W-1:0] = ctl;
        end else if (hit_stat) begin
            skip_rdata[STAT_BSY] = flash_busy;
        end else if (hit_data) begin
            skip_rdata = host_wide ? {HOST_W{1'b1}} : {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};
        end
    end

    nbb_regs #(.SYNC_STAGES(SYNC_STAGES)) u_regs (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(host_wdata[BYTE_W-1:0]),
        .rb_n(nand_rb_n), .ctl(ctl), .flash_busy(flash_busy)
    );

    nbb_seq #(
        .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC), .HOLD_CYC(HOLD_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_wr(host_we),
        .start_wide(host_wide), .start_skip(skip), .skip_rdata(skip_rdata),
        .wdata(host_wdata), .dq_i(nand_dq_i), .idle(seq_idle), .done(host_ready),
        .rdata(host_rdata), .we_n(nand_we_n), .re_n(nand_re_n),
        .dq_o(nand_dq_o), .dq_oe(nand_dq_oe)
    );

    always_comb begin
        nand_ce_n = !ctl[CTL_SEL];
        nand_cle  = ctl[CTL_CLE];
        nand_ale  = ctl[CTL_ALE];
        nand_wp_n = ctl[CTL_WPR];
    end

    // R9
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> !host_ready);

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    // R10
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nand_ce_n |-> (nand_we_n && nand_re_n));
endmodule

// File: tb/nand_byte_bridge_test.sv
module nand_byte_bridge_test;
    localparam int S = 2, P = 3, H = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0, host_wide = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_ready;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_wp_n;
    logic [7:0]  nand_dq_o;
    logic        nand_dq_oe;
    logic [7:0]  nand_dq_i;
    logic        nand_rb_n = 1'b1;

    always #2.5 clk = ~clk;

    nand_byte_bridge #(.SETUP_CYC(S), .STROBE_CYC(P), .HOLD_CYC(H)) uut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_wide(host_wide), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_ready(host_ready), .nand_ce_n(nand_ce_n),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_wp_n(nand_wp_n), .nand_dq_o(nand_dq_o),
        .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_rb_n(nand_rb_n)
    );

    // flash model
    function automatic logic [7:0] fbyte(int p);
        return 8'((p * 37 + 5) & 255);
    endfunction

    int rd_ptr = 0, wcnt = 0, we_low = 0, re_low = 0;
    logic [7:0] wlog [64];
    assign nand_dq_i = fbyte(rd_ptr);
    always @(posedge nand_we_n) if (rst_n) begin wlog[wcnt % 64] = nand_dq_o; wcnt++; end
    always @(posedge nand_re_n) if (rst_n) rd_ptr++;
    always @(negedge clk) begin
        if (rst_n && !nand_we_n) we_low++;
        if (rst_n && !nand_re_n) re_low++;
    end

    int n_chk = 0, n_fail = 0;
    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic wide, input logic [2:0] a,
                          input logic [15:0] wd, output logic [15:0] rd, output int cyc);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_wide = wide; host_addr = a; host_wdata = wd;
        cyc = 0;
        for (int k = 0; k < 1000; k++) begin
            @(posedge clk); cyc++;
            @(negedge clk);
            if (host_ready) break;
        end
        rd = host_rdata;
        host_req = 1'b0;
    endtask

    typedef struct packed {
        logic        we;
        logic        wide;
        logic [2:0]  addr;
        logic [15:0] wdata;
        logic [15:0] exp_rd;
        logic        flash;
        logic [4:0]  cyc;
        logic [1:0]  nw;
        logic [1:0]  nr;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VT [NV] = '{
        '{1'b0,1'b0,3'd4,16'h0000,16'h0000,1'b0,5'd1,2'd0,2'd0,4'd2},   // R2
        '{1'b0,1'b1,3'd0,16'h0000,16'hFFFF,1'b0,5'd1,2'd0,2'd0,4'd10},  // R10
        '{1'b0,1'b0,3'd0,16'h0000,16'h00FF,1'b0,5'd1,2'd0,2'd0,4'd10},  // R10
        '{1'b1,1'b1,3'd0,16'hBEEF,16'h0000,1'b0,5'd1,2'd0,2'd0,4'd10},  // R10
        '{1'b1,1'b0,3'd4,16'h0095,16'h0000,1'b0,5'd1,2'd0,2'd0,4'd2},   // R2
        '{1'b0,1'b0,3'd4,16'h0000,16'h0095,1'b0,5'd1,2'd0,2'd0,4'd2},   // R2
        '{1'b1,1'b0,3'd0,16'h1234,16'h0000,1'b0,5'd7,2'd1,2'd0,4'd6},   // R6
        '{1'b1,1'b0,3'd4,16'h0096,16'h0000,1'b0,5'd1,2'd0,2'd0,4'd2},   // R2
        '{1'b1,1'b0,3'd0,16'h00AB,16'h0000,1'b0,5'd7,2'd1,2'd0,4'd6},   // R6
        '{1'b1,1'b0,3'd4,16'h0094,16'h0000,1'b0,5'd1,2'd0,2'd0,4'd2},   // R2
        '{1'b1,1'b1,3'd0,16'hBEEF,16'h0000,1'b0,5'd13,2'd2,2'd0,4'd4},  // R4
        '{1'b0,1'b1,3'd0,16'h0000,16'h0000,1'b1,5'd13,2'd0,2'd2,4'd5},  // R5
        '{1'b0,1'b0,3'd0,16'h0000,16'h0000,1'b1,5'd7,2'd0,2'd1,4'd7},   // R7
        '{1'b0,1'b0,3'd5,16'h0000,16'h0000,1'b0,5'd1,2'd0,2'd0,4'd3},   // R3
        '{1'b1,1'b0,3'd5,16'h00FF,16'h0000,1'b0,5'd1,2'd0,2'd0,4'd3},   // R3
        '{1'b0,1'b0,3'd5,16'h0000,16'h0000,1'b0,5'd1,2'd0,2'd0,4'd3},   // R3
        '{1'b1,1'b0,3'd2,16'h5A5A,16'h0000,1'b0,5'd1,2'd0,2'd0,4'd11},  // R11
        '{1'b0,1'b0,3'd2,16'h0000,16'h0000,1'b0,5'd1,2'd0,2'd0,4'd11},  // R11
        '{1'b0,1'b1,3'd4,16'h0000,16'h0094,1'b0,5'd1,2'd0,2'd0,4'd2},   // R2
        '{1'b1,1'b1,3'd0,16'h1357,16'h0000,1'b0,5'd13,2'd2,2'd0,4'd4},  // R4
        '{1'b1,1'b0,3'd4,16'h0000,16'h0000,1'b0,5'd1,2'd0,2'd0,4'd10},  // R10
        '{1'b0,1'b1,3'd0,16'h0000,16'hFFFF,1'b0,5'd1,2'd0,2'd0,4'd10},  // R10
        '{1'b1,1'b0,3'd4,16'h0094,16'h0000,1'b0,5'd1,2'd0,2'd0,4'd2}    // R2
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        int cyc;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 ce_n", nand_ce_n, 1);
        chk("R1 strobes", {nand_we_n, nand_re_n}, 2'b11);
        chk("R1 latches/wp/oe/ready", {nand_cle, nand_ale, nand_wp_n, nand_dq_oe, host_ready}, 5'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {nand_ce_n, nand_we_n, nand_re_n, host_ready}, 4'b1110);

        for (int i = 0; i < NV; i++) begin
            vec_t v = VT[i];
            string tag = $sformatf("R%0d row %0d", v.req, i);
            int w0 = wcnt, r0 = rd_ptr;
            logic [15:0] exp;
            we_low = 0; re_low = 0;
            exp = v.flash ? (v.wide ? {fbyte(r0 + 1), fbyte(r0)} : {8'h00, fbyte(r0)}) : v.exp_rd;
            access(v.we, v.wide, v.addr, v.wdata, rd, cyc);
            chk({tag, " cycles"}, cyc, v.cyc);          // R8
            chk({tag, " writes"}, wcnt - w0, v.nw);
            chk({tag, " reads"}, rd_ptr - r0, v.nr);
            chk({tag, " R8 strobe clocks"}, we_low + re_low, (v.nw + v.nr) * P);
            if (!v.we) chk({tag, " rdata"}, rd, exp);
            if (v.nw >= 1) chk({tag, " first byte"}, wlog[w0 % 64], v.wdata[7:0]);
            if (v.nw == 2) chk({tag, " second byte"}, wlog[(w0 + 1) % 64], v.wdata[15:8]);
        end

        // R2 control bits at the pins
        access(1'b1, 1'b0, 3'd4, 16'h0095, rd, cyc);
        chk("R2 cmd pins", {nand_ce_n, nand_cle, nand_ale, nand_wp_n}, 4'b0101);
        access(1'b1, 1'b0, 3'd4, 16'h0096, rd, cyc);
        chk("R2 addr pins", {nand_ce_n, nand_cle, nand_ale, nand_wp_n}, 4'b0011);
        access(1'b1, 1'b0, 3'd4, 16'h0000, rd, cyc);
        chk("R2 standby pins", {nand_ce_n, nand_cle, nand_ale, nand_wp_n}, 4'b1000);

        // R3 busy status
        nand_rb_n = 1'b0;
        repeat (4) @(negedge clk);
        access(1'b0, 1'b0, 3'd5, 16'h0000, rd, cyc);
        chk("R3 busy", rd, 16'h0080);
        nand_rb_n = 1'b1;
        repeat (4) @(negedge clk);
        access(1'b0, 1'b0, 3'd5, 16'h0000, rd, cyc);
        chk("R3 ready", rd, 16'h0000);

        // R9 ready lasts one clock
        access(1'b1, 1'b0, 3'd4, 16'h0094, rd, cyc);
        access(1'b1, 1'b1, 3'd0, 16'hA55A, rd, cyc);
        @(negedge clk);
        chk("R9 ready pulse", host_ready, 0);
        chk("R9 oe released", nand_dq_oe, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule